// File: doc/BRIEF.md
# Interpolating Root-Raised-Cosine Pulse Shaper

This block shapes one rail of a spread-spectrum transmit baseband. Chips of value +1 or -1 arrive with a chip strobe. A separate strobe, running at four times the chip rate, pushes one sample per pulse into a 65-entry delay line. That sample is the waiting chip when there is one and zero when there is not, so upsampling and zero insertion follow from the strobe ratio. Each pushed sample starts a filter evaluation. The evaluation runs through a pipelined datapath: symmetric taps are folded, 33 radix-4 Booth multipliers work in parallel, an accumulator adds the products, and a final stage rounds and saturates the result to a signed 16-bit output sample.

The coefficients are fixed integers in units of 2^-16, given as a parameter array that holds taps 0 to 32. Because the impulse response is symmetric, tap j equals tap 64-j. The I and Q rails each use their own instance. The pipeline is built to meet a 10 ns clock period. At 100 MHz and 15.36 Msample/s, a new sample arrives only every six or seven clocks, but the datapath still accepts one sample every clock.

Top module: `rrc_pulse_shaper`

## Requirements
- R1: While rst_n is low, out_sample is 0, out_valid is 0, every delay-line entry is zero and no chip is waiting. A sample strobe after reset with no chip yields output 0, whatever the stream held before the reset.
- R2: chip_in is a 2-bit two's-complement value: 2'b01 means +1 and 2'b11 means -1. It is taken only in cycles where chip_stb is high.
- R3: Each cycle with smp_stb high shifts exactly one value into the 65-entry line. That value is the waiting chip if there is one, otherwise zero. A chip enters the line once and is not repeated at later strobes. The line does not change in cycles without smp_stb.
- R4: A chip whose chip_stb falls in the same cycle as smp_stb enters the line at that strobe, even if an older chip is waiting. A chip whose chip_stb falls in a cycle without smp_stb waits for the next strobe. A newer chip that arrives while one is waiting replaces it.
- R5: Before scaling, the filter result is the sum over j = 0..64 of b(j)·x(n-j), where x(n) is the newest line entry, b(j) = COEF[j] for j ≤ 32, and b(j) = COEF[64-j] for j > 32.
- R6: out_valid pulses high for one cycle following the fourth rising edge after the edge that samples smp_stb. Strobes on consecutive cycles produce outputs on consecutive cycles.
- R7: With OUT_SHIFT = 0, a single +1 chip followed by zero samples reproduces b(0) to b(64) on 65 successive outputs. A single -1 chip reproduces their negatives.
- R8: The result is divided by 2^OUT_SHIFT and rounded to the nearest integer, with exact halves rounded toward plus infinity (-19.5 gives -19, 29.5 gives 30).
- R9: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R10: out_sample keeps its last value in cycles where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_stb | input | 1 | Chip strobe: chip_in is valid this cycle |
| chip_in | input | DATA_W | Signed chip value |
| smp_stb | input | 1 | Output-rate strobe: push one sample and start one evaluation |
| out_sample | output | OUT_W | Rounded, saturated filter output |
| out_valid | output | 1 | out_sample carries a new result this cycle |

## Verification
A chip arrival and a sample push can happen in the same cycle. A chip can also arrive while an older chip is still waiting for its strobe. The bench creates both cases after a flush to all zeros. It raises chip_stb together with smp_stb, or raises chip_stb alone one or more times before a bare strobe. It then reads the newest-entry contribution b(0)·x at the output four edges later, which shows which chip entered the line. The strobe that follows must show the chip one position deeper and a zero in front of it.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  // Taps 0..32 of the default 65-tap response, units of 2^-16; tap j = tap 64-j.
  localparam int RRC_DEFAULT_COEF [33] = '{
    -78, 12, 103, 118, 36, -82, -136, -71, 64, 150, 92, -81, -220,
    -150, 120, 300, 220, -140, -420, -380, 90, 600, 640, 80,
    -900, -1400, -700, 1500, 4700, 8600, 12600, 15500, 16600
  };

  // Radix-4 Booth digit for the bit triple {b(2i+1), b(2i), b(2i-1)}.
  function automatic logic signed [2:0] booth_digit(input logic [2:0] trip);
    case (trip)
      3'b001, 3'b010: return 3'sd1;
      3'b011:         return 3'sd2;
      3'b100:         return -3'sd2;
      3'b101, 3'b110: return -3'sd1;
      default:        return 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/rrc_booth_mul.sv
module rrc_booth_mul #(
  parameter int A_W = 3,
  parameter int B_W = 16,
  parameter int P_W = A_W + B_W
) (
  input  logic signed [A_W-1:0] a,
  input  logic signed [B_W-1:0] b,
  output logic signed [P_W-1:0] prod
);
  localparam int ND  = (A_W + 1) / 2;
  localparam int EXT = 2 * ND;

  logic signed [EXT-1:0] a_sx;
  logic        [EXT:0]   a_ext;
  logic signed [P_W-1:0] b_sx;
  logic signed [P_W-1:0] pp [ND];

  function automatic logic signed [P_W-1:0] pick_pp(input logic signed [2:0] dig,
                                                    input logic signed [P_W-1:0] m);
    case (dig)
      3'sd1:   return m;
      3'sd2:   return m <<< 1;
      -3'sd1:  return -m;
      -3'sd2:  return -(m <<< 1);
      default: return '0;
    endcase
  endfunction

  assign a_sx  = EXT'(a);
  assign a_ext = {a_sx, 1'b0};
  assign b_sx  = P_W'(b);

  for (genvar g = 0; g < ND; g++) begin : g_pp
    logic signed [2:0] dig;
    assign dig   = rrc_pkg::booth_digit(a_ext[2*g+2 -: 3]);
    assign pp[g] = pick_pp(dig, b_sx);
  end

  always_comb begin
    prod = '0;
    for (int g = 0; g < ND; g++) prod = prod + (pp[g] <<< (2 * g));
  end
endmodule

// File: rtl/rrc_tap_line.sv
module rrc_tap_line #(
  parameter int NUM_TAPS = 65,
  parameter int DATA_W   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               chip_stb,
  input  logic [DATA_W-1:0]                  chip_in,
  input  logic                               smp_stb,
  output logic [NUM_TAPS-1:0][DATA_W-1:0]    taps,
  output logic                               line_valid
);
  logic              pend_q;
  logic [DATA_W-1:0] pend_d;
  logic [DATA_W-1:0] line_x;
  logic              chip_direct;
  logic              stuff_zero;

  assign chip_direct = smp_stb & chip_stb;
  assign stuff_zero  = smp_stb & ~chip_stb & ~pend_q;

  always_comb begin
    if (chip_stb)    line_x = chip_in;
    else if (pend_q) line_x = pend_d;
    else             line_x = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_d     <= '0;
      taps       <= '0;
      line_valid <= 1'b0;
    end else begin
      line_valid <= smp_stb;
      if (smp_stb) begin
        taps   <= {taps[NUM_TAPS-2:0], line_x};
        pend_q <= 1'b0;
      end else if (chip_stb) begin
        pend_q <= 1'b1;
        pend_d <= chip_in;
      end
    end
  end

  assert_zero_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_zero |=> taps[0] == '0);
  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> taps[NUM_TAPS-1:1] == $past(taps[NUM_TAPS-2:0]));
  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(taps));
  assert_direct_chip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_direct |=> taps[0] == $past(chip_in));
  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !pend_q);
endmodule

// File: rtl/rrc_mac.sv
module rrc_mac #(
  parameter int NUM_TAPS = 65,
  parameter int DATA_W   = 2,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 25,
  parameter int COEF [NUM_TAPS/2+1] = rrc_pkg::RRC_DEFAULT_COEF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] taps,
  output logic signed [ACC_W-1:0]         acc,
  output logic                            acc_valid
);
  localparam int HALF   = NUM_TAPS / 2;
  localparam int NU     = HALF + 1;
  localparam int FOLD_W = DATA_W + 1;
  localparam int PROD_W = FOLD_W + COEF_W;

  function automatic longint abs_weight();
    longint s = 0;
    for (int k = 0; k < NU; k++) begin
      longint c = (COEF[k] < 0) ? -longint'(COEF[k]) : longint'(COEF[k]);
      s += (k == HALF) ? c : 2 * c;
    end
    return s;
  endfunction

  localparam longint ACC_BOUND = abs_weight() * (longint'(1) << (DATA_W - 1));

  function automatic logic signed [FOLD_W-1:0] widen(input logic [DATA_W-1:0] v);
    return FOLD_W'(signed'(v));
  endfunction

  logic signed [FOLD_W-1:0] fold_c [NU];
  logic signed [FOLD_W-1:0] fold_q [NU];
  logic signed [PROD_W-1:0] prod_c [NU];
  logic signed [PROD_W-1:0] prod_q [NU];
  logic signed [ACC_W-1:0]  sum_c;
  logic                     v1, v2;

  for (genvar k = 0; k < NU; k++) begin : g_tap
    localparam logic signed [COEF_W-1:0] CK = COEF_W'(COEF[k]);
    if (k < HALF) begin : g_pair
      assign fold_c[k] = widen(taps[k]) + widen(taps[NUM_TAPS-1-k]);
    end else begin : g_centre
      assign fold_c[k] = widen(taps[k]);
    end
    rrc_booth_mul #(.A_W(FOLD_W), .B_W(COEF_W), .P_W(PROD_W)) u_mul (
      .a(fold_q[k]), .b(CK), .prod(prod_c[k])
    );
  end

  always_comb begin
    sum_c = '0;
    for (int k = 0; k < NU; k++) sum_c = sum_c + ACC_W'(prod_q[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      acc_valid <= 1'b0;
      acc       <= '0;
      for (int k = 0; k < NU; k++) begin
        fold_q[k] <= '0;
        prod_q[k] <= '0;
      end
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      acc_valid <= v2;
      if (in_valid) for (int k = 0; k < NU; k++) fold_q[k] <= fold_c[k];
      if (v1)       for (int k = 0; k < NU; k++) prod_q[k] <= prod_c[k];
      if (v2)       acc <= sum_c;
    end
  end

  assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (longint'(acc) <= ACC_BOUND && longint'(acc) >= -ACC_BOUND));
  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> $stable(acc));
endmodule

// File: rtl/rrc_round_sat.sv
module rrc_round_sat #(
  parameter int ACC_W     = 25,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    acc_valid,
  output logic [OUT_W-1:0]        out_sample,
  output logic                    out_valid
);
  localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'(2**(OUT_W-1) - 1);
  localparam logic signed [ACC_W:0] MINV = -(ACC_W+1)'(2**(OUT_W-1));

  logic signed [ACC_W:0] acc_x;
  logic signed [ACC_W:0] rnd;
  logic                  sat_hi, sat_lo;

  assign acc_x = (ACC_W+1)'(acc);

  if (OUT_SHIFT == 0) begin : g_exact
    assign rnd = acc_x;
  end else begin : g_round
    localparam logic signed [ACC_W:0] HALF_LSB = (ACC_W+1)'(2**(OUT_SHIFT-1));
    assign rnd = (acc_x + HALF_LSB) >>> OUT_SHIFT;
  end

  assign sat_hi = rnd > MAXV;
  assign sat_lo = rnd < MINV;

  function automatic logic [OUT_W-1:0] clamp(input logic signed [ACC_W:0] v,
                                             input logic hi, input logic lo);
    if (hi)      return MAXV[OUT_W-1:0];
    else if (lo) return MINV[OUT_W-1:0];
    else         return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) out_sample <= clamp(rnd, sat_hi, sat_lo);
    end
  end

  assert_sat_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sat_hi) |=> out_sample == MAXV[OUT_W-1:0]);
  assert_sat_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sat_lo) |=> out_sample == MINV[OUT_W-1:0]);
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(out_sample));
endmodule

// File: rtl/rrc_pulse_shaper.sv
module rrc_pulse_shaper #(
  parameter int NUM_TAPS  = 65,
  parameter int DATA_W    = 2,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 0,
  parameter int COEF [NUM_TAPS/2+1] = rrc_pkg::RRC_DEFAULT_COEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_stb,
  input  logic [DATA_W-1:0] chip_in,
  input  logic              smp_stb,
  output logic [OUT_W-1:0]  out_sample,
  output logic              out_valid
);
  localparam int NU     = NUM_TAPS / 2 + 1;
  localparam int PROD_W = DATA_W + 1 + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NU);

  logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
  logic                            line_valid;
  logic signed [ACC_W-1:0]         acc;
  logic                            acc_valid;

  rrc_tap_line #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .chip_in(chip_in),
    .smp_stb(smp_stb), .taps(taps), .line_valid(line_valid)
  );

  rrc_mac #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
            .ACC_W(ACC_W), .COEF(COEF)) u_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(line_valid), .taps(taps),
    .acc(acc), .acc_valid(acc_valid)
  );

  rrc_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_out (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_valid(acc_valid),
    .out_sample(out_sample), .out_valid(out_valid)
  );

  // Shadow of the strobe, four edges deep, for the latency check.
  logic [3:0] lat_sr;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_sr <= '0;
    else        lat_sr <= {lat_sr[2:0], smp_stb};
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lat_sr[3] |=> out_valid);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_sr[3] |=> !out_valid);
endmodule

// File: tb/tb_rrc_pulse_shaper.sv
module tb_rrc_pulse_shaper;
  localparam int CF [33] = '{
    -78, 12, 103, 118, 36, -82, -136, -71, 64, 150, 92, -81, -220,
    -150, 120, 300, 220, -140, -420, -380, 90, 600, 640, 80,
    -900, -1400, -700, 1500, 4700, 8600, 12600, 15500, 16600
  };
  localparam int NVEC = 24;
  localparam logic [1:0] CHIPS [NVEC] = '{
    2'b01, 2'b01, 2'b11, 2'b01, 2'b11, 2'b11, 2'b01, 2'b11,
    2'b01, 2'b01, 2'b01, 2'b11, 2'b11, 2'b01, 2'b11, 2'b01,
    2'b11, 2'b11, 2'b11, 2'b01, 2'b01, 2'b11, 2'b01, 2'b01
  };

  logic clk = 1'b0, rst_n = 1'b0, chip_stb = 1'b0, smp_stb = 1'b0;
  logic [1:0] chip_in = '0;
  logic [15:0] out_sample, out_sample_r;
  logic out_valid, out_valid_r;
  int n_chk = 0, n_fail = 0;

  int hist [65];
  bit pend = 0;
  int pend_v = 0;

  always #5 clk = ~clk;

  rrc_pulse_shaper #(.COEF(CF)) dut (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .chip_in(chip_in),
    .smp_stb(smp_stb), .out_sample(out_sample), .out_valid(out_valid));

  rrc_pulse_shaper #(.COEF(CF), .OUT_SHIFT(2)) dut_rnd (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .chip_in(chip_in),
    .smp_stb(smp_stb), .out_sample(out_sample_r), .out_valid(out_valid_r));

  function automatic int coef_at(int j);
    return (j <= 32) ? CF[j] : CF[64 - j];
  endfunction

  function automatic int ref_acc();
    int s = 0;
    for (int j = 0; j < 65; j++) s += hist[j] * coef_at(j);
    return s;
  endfunction

  function automatic int ref_out(int a, int sh);
    int v;
    if (sh == 0) v = a;
    else v = int'($floor(real'(a) / (2.0 ** sh) + 0.5));
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < 65; j++) hist[j] = 0;
    pend = 0;
    pend_v = 0;
  endtask

  task automatic model_edge(bit cs, int cv, bit ss);
    if (ss) begin
      for (int j = 64; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = cs ? cv : (pend ? pend_v : 0);
      pend = 0;
    end else if (cs) begin
      pend = 1;
      pend_v = cv;
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic drive(bit cs, int cv, bit ss);
    chip_stb = cs;
    chip_in  = cv[1:0];
    smp_stb  = ss;
    @(posedge clk);
    model_edge(cs, cv, ss);
    @(negedge clk);
    chip_stb = 1'b0;
    smp_stb  = 1'b0;
  endtask

  task automatic sample_check(bit cs, int cv, string req, output int got0, output int gotr);
    int e0, er;
    drive(cs, cv, 1'b1);
    e0 = ref_out(ref_acc(), 0);
    er = ref_out(ref_acc(), 2);
    repeat (3) @(negedge clk);
    check("R6", "valid early", int'(out_valid), 0);
    @(negedge clk);
    check("R6", "valid on time", int'(out_valid), 1);
    check("R6", "valid on time (shift 2)", int'(out_valid_r), 1);
    got0 = int'($signed(out_sample));
    gotr = int'($signed(out_sample_r));
    check(req, "sample", got0, e0);
    check(req, "sample shift 2", gotr, er);
  endtask

  task automatic flush();
    repeat (65) drive(1'b0, 0, 1'b1);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g0, gr, held;
    int exp3 [3];
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_sample in reset", int'(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    sample_check(1'b0, 0, "R1", g0, gr);
    check("R1", "cleared line", g0, 0);

    // R7/R5: positive impulse reproduces the coefficients; R8 on shift-2 copy
    for (int i = 0; i < 65; i++) begin
      sample_check(i == 0, 1, "R5", g0, gr);
      check("R7", "impulse tap", g0, coef_at(i));
      if (i == 0) check("R8", "-19.5 rounds up", gr, -19);
      if (i == 1) check("R8", "12/4", gr, 3);
      if (i == 3) check("R8", "29.5 rounds up", gr, 30);
    end
    // R2/R7: negative chip gives negated taps
    for (int i = 0; i < 8; i++) begin
      sample_check(i == 0, -1, "R2", g0, gr);
      check("R7", "negative impulse", g0, -coef_at(i));
    end
    flush();

    // Vector table: one chip then three stuffed zeros (R3, R5, R8)
    for (int v = 0; v < NVEC; v++) begin
      sample_check(1'b1, int'($signed(CHIPS[v])), "R5", g0, gr);
      for (int z = 0; z < 3; z++) sample_check(1'b0, 0, "R3", g0, gr);
    end
    flush();

    // R4: chip waiting for a later strobe
    drive(1'b1, 1, 1'b0);
    repeat (2) @(negedge clk);
    sample_check(1'b0, 0, "R4", g0, gr);
    check("R4", "deferred chip", g0, -78);
    sample_check(1'b0, 0, "R3", g0, gr);
    check("R3", "no repeat after use", g0, 12);
    flush();
    // R4: newer waiting chip replaces older one
    drive(1'b1, 1, 1'b0);
    drive(1'b1, -1, 1'b0);
    sample_check(1'b0, 0, "R4", g0, gr);
    check("R4", "replaced chip", g0, 78);
    flush();
    // R4: same-cycle chip wins over waiting chip; waiting one is dropped
    drive(1'b1, 1, 1'b0);
    sample_check(1'b1, -1, "R4", g0, gr);
    check("R4", "direct chip", g0, 78);
    sample_check(1'b0, 0, "R4", g0, gr);
    check("R4", "waiting chip dropped", g0, -12);

    // R6: three strobes on consecutive cycles
    flush();
    for (int i = 0; i < 3; i++) begin
      chip_stb = 1'b1; chip_in = 2'b01; smp_stb = 1'b1;
      @(posedge clk);
      model_edge(1'b1, 1, 1'b1);
      exp3[i] = ref_out(ref_acc(), 0);
      @(negedge clk);
    end
    chip_stb = 1'b0; smp_stb = 1'b0;
    @(negedge clk);
    check("R6", "burst valid early", int'(out_valid), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6", "burst valid", int'(out_valid), 1);
      check("R6", "burst sample", int'($signed(out_sample)), exp3[i]);
    end
    @(negedge clk);
    check("R6", "burst end", int'(out_valid), 0);

    // R10: output holds between pulses
    held = int'($signed(out_sample));
    repeat (5) @(negedge clk);
    check("R10", "hold sample", int'($signed(out_sample)), held);
    check("R10", "valid low idle", int'(out_valid), 0);

    // R9: all +1 at every strobe saturates high
    for (int i = 0; i < 65; i++) sample_check(1'b1, 1, "R9", g0, gr);
    check("R9", "clamp high", g0, 32767);
    // R9: sign-opposed pattern saturates low
    for (int j = 64; j >= 0; j--) sample_check(1'b1, (coef_at(j) < 0) ? 1 : -1, "R9", g0, gr);
    check("R9", "clamp low", g0, -32768);
    check("R8", "negative half on shift 2", gr, ref_out(ref_acc(), 2));

    // R1: reset in mid-stream clears the line
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "out_sample after reset", int'(out_sample), 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    sample_check(1'b0, 0, "R1", g0, gr);
    check("R1", "line empty after reset", g0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule